// File: doc/BRIEF.md
# Third-order multibit noise shaper

This block requantizes one channel of an oversampled, high-resolution audio stream into a 4-bit code for a DAC with 15 unit elements. It uses error feedback with a third-order noise transfer function, (1 - z^-1)^3. The quantization error is therefore pushed far above the audio band, and the low-frequency signal-to-noise ratio stays high. Stereo use takes two instances.

A signed 24-bit sample is taken on each accepted strobe. The block has two strobe inputs, one running at 128 times the base rate and one at 256 times. A rate-select input picks which of the two is honoured, and this is the only effect of the rate choice. Each accepted strobe produces one registered output code and a one-cycle valid pulse. A sticky clip flag reports any quantizer overload. A synchronous clear returns the loop to its reset state.

Top module: `ns3_noise_shaper`

## Requirements
- R1: After rst_ni is asserted, or after an edge where clr_i is high, code_o is 8, valid_o is 0 and clip_o is 0, and all three stored error terms are zero. clr_i takes priority over a strobe in the same cycle, and that strobe is discarded.
- R2: When rate_sel_i is 0, only en_lo_i (the 128x strobe) is accepted. When rate_sel_i is 1, only en_hi_i (the 256x strobe) is accepted. The strobe that is not selected has no effect on any output or on the state.
- R3: code_o, clip_o and valid_o update at the clock edge where an accepted strobe is sampled high, and valid_o is high for exactly the following cycle. In a cycle without an accepted strobe, code_o, clip_o and the error state are unchanged and valid_o is 0.
- R4: The quantizer input is v = x + 3*e1 - 3*e2 + e3. Here x is sample_i as a signed integer, and e1, e2 and e3 are the errors stored at the last three accepted strobes, newest first. Each error is e = v - (code - 8) * 2^20.
- R5: code_o is an unsigned 4-bit value equal to floor(v / 2^20) + 8, clamped to the range 0..15. Code 8 is mid-scale, so a zero input held from the cleared state gives code 8 on every strobe.
- R6: Each stored error is saturated to the signed 24-bit range -2^23 .. 2^23-1 instead of wrapping.
- R7: clip_o is set at a strobe where floor(v / 2^20) + 8 lies outside 0..15. It then stays set until reset or clear.
- R8: For a constant input x with |x| <= 3*2^20, applied from the cleared state, the average of code_o over 512 strobes is within 1 of x / 2^20 + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of loop state and clip flag |
| rate_sel_i | input | 1 | 0 selects en_lo_i (128x), 1 selects en_hi_i (256x) |
| en_lo_i | input | 1 | Sample strobe at 128x the base rate |
| en_hi_i | input | 1 | Sample strobe at 256x the base rate |
| sample_i | input | 24 | Signed input sample |
| code_o | output | 4 | Quantized element-count code, 0..15 |
| valid_o | output | 1 | High for one cycle after each accepted strobe |
| clip_o | output | 1 | Sticky quantizer overload flag |

## Verification
Two events can land on the same edge: the synchronous clear and an accepted strobe. That strobe may carry a full-scale sample that would clip or update the error state. The bench provokes this case on purpose. It first drives the loop into saturation with a constant full-scale input. It then raises clr_i together with a selected strobe and a full-scale sample. The result is judged correct only if code_o returns to 8 with clip_o and valid_o low, and if zero-input strobes after that give mid-scale codes, which shows that no error from the dropped strobe was stored.

// File: rtl/ns3_pkg.sv
package ns3_pkg;
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  // coefficient of z^-k in (1 - z^-1)^n
  function automatic int ntf_coef(input int n, input int k);
    return ((k % 2) == 1) ? -binom(n, k) : binom(n, k);
  endfunction
endpackage

// File: rtl/ns3_strobe_sel.sv
module ns3_strobe_sel (
  input  logic rate_sel_i,
  input  logic en_lo_i,
  input  logic en_hi_i,
  output logic en_o
);
  logic [1:0] en_vec;
  assign en_vec = {en_hi_i, en_lo_i};
  assign en_o   = en_vec[rate_sel_i];
endmodule

// File: rtl/ns3_quantizer.sv
module ns3_quantizer #(
  parameter int W      = 24,
  parameter int CODE_W = 4,
  parameter int VW     = 28
) (
  input  logic signed [VW-1:0] v_i,
  output logic [CODE_W-1:0]    code_o,
  output logic signed [W-1:0]  err_o,
  output logic                 clip_o
);
  localparam int SHIFT = W - CODE_W;
  localparam int MID   = 2 ** (CODE_W - 1);
  localparam int CMAX  = 2 ** CODE_W - 1;
  localparam logic signed [VW-1:0] MID_V  = VW'(MID);
  localparam logic signed [VW-1:0] CMAX_V = VW'(CMAX);
  localparam logic signed [VW-1:0] EMAX_V = VW'((2 ** (W - 1)) - 1);
  localparam logic signed [VW-1:0] EMIN_V = -(VW'(2 ** (W - 1)));

  logic signed [VW-1:0] lvl;
  logic signed [VW-1:0] lvl_c;
  logic signed [VW-1:0] recon;
  logic signed [VW-1:0] diff;

  always_comb begin
    lvl    = (v_i >>> SHIFT) + MID_V;
    clip_o = 1'b0;
    lvl_c  = lvl;
    if (lvl < 0) begin
      lvl_c  = '0;
      clip_o = 1'b1;
    end else if (lvl > CMAX_V) begin
      lvl_c  = CMAX_V;
      clip_o = 1'b1;
    end
    code_o = lvl_c[CODE_W-1:0];
    recon  = (lvl_c - MID_V) <<< SHIFT;
    diff   = v_i - recon;
    if (diff > EMAX_V)      err_o = EMAX_V[W-1:0];
    else if (diff < EMIN_V) err_o = EMIN_V[W-1:0];
    else                    err_o = diff[W-1:0];
  end
endmodule

// File: rtl/ns3_loop_filter.sv
module ns3_loop_filter
  import ns3_pkg::*;
#(
  parameter int W     = 24,
  parameter int ORDER = 3,
  parameter int VW    = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  err_i,
  output logic signed [VW-1:0] v_o
);
  logic signed [W-1:0]  err_q [ORDER];
  logic signed [VW-1:0] term  [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_tap
    localparam logic signed [VW-1:0] GAIN = VW'(-ntf_coef(ORDER, k + 1));
    logic signed [VW-1:0] e_ext;
    assign e_ext   = VW'(err_q[k]);
    assign term[k] = GAIN * e_ext;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    err_q[k] <= '0;
      else if (clr_i) err_q[k] <= '0;
      else if (en_i) begin
        if (k == 0) err_q[k] <= err_i;
        else        err_q[k] <= err_q[(k == 0) ? 0 : k - 1];
      end
    end
  end

  always_comb begin
    v_o = VW'(x_i);
    for (int k = 0; k < ORDER; k++) v_o = v_o + term[k];
  end
endmodule

// File: rtl/ns3_noise_shaper.sv
module ns3_noise_shaper #(
  parameter int W      = 24,
  parameter int CODE_W = 4,
  parameter int ORDER  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rate_sel_i,
  input  logic              en_lo_i,
  input  logic              en_hi_i,
  input  logic [W-1:0]      sample_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              clip_o
);
  localparam int VW   = W + ORDER + 1;
  localparam int STEP = 2 ** (W - CODE_W);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(2 ** (CODE_W - 1));

  logic                 en;
  logic signed [VW-1:0] v;
  logic [CODE_W-1:0]    q_code;
  logic signed [W-1:0]  q_err;
  logic                 q_clip;

  ns3_strobe_sel u_sel (
    .rate_sel_i (rate_sel_i),
    .en_lo_i    (en_lo_i),
    .en_hi_i    (en_hi_i),
    .en_o       (en)
  );

  ns3_loop_filter #(.W(W), .ORDER(ORDER), .VW(VW)) u_lf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (en),
    .x_i    ($signed(sample_i)),
    .err_i  (q_err),
    .v_o    (v)
  );

  ns3_quantizer #(.W(W), .CODE_W(CODE_W), .VW(VW)) u_q (
    .v_i    (v),
    .code_o (q_code),
    .err_o  (q_err),
    .clip_o (q_clip)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= MID_CODE;
      valid_o <= 1'b0;
      clip_o  <= 1'b0;
    end else if (clr_i) begin
      code_o  <= MID_CODE;
      valid_o <= 1'b0;
      clip_o  <= 1'b0;
    end else begin
      valid_o <= en;
      if (en) begin
        code_o <= q_code;
        clip_o <= clip_o | q_clip;
      end
    end
  end

  // R1: clear wins over any strobe
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (code_o == MID_CODE && !clip_o && !valid_o));

  // R3: no accepted strobe holds the output
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !clr_i) |=> ($stable(code_o) && $stable(clip_o) && !valid_o));

  // R3: one-cycle latency of valid
  a_r3_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !clr_i) |=> valid_o);

  // R5: unclipped residue stays within one quantizer step
  a_r5_err_in_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !q_clip) |-> (q_err >= 0 && q_err < STEP));

  // R7: clip flag is sticky
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clip_o && !clr_i) |=> clip_o);
endmodule

// File: tb/ns3_noise_shaper_tb_top.sv
module ns3_noise_shaper_tb_top;
  localparam longint S    = 64'sd1 <<< 20;
  localparam longint EMAX = (64'sd1 <<< 23) - 1;
  localparam longint EMIN = -(64'sd1 <<< 23);

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        rate_sel_i = 1'b1;
  logic        en_lo_i = 1'b0;
  logic        en_hi_i = 1'b0;
  logic [23:0] sample_i = '0;
  logic [3:0]  code_o;
  logic        valid_o;
  logic        clip_o;

  int n_vec = 0;
  int n_bad = 0;

  longint m_e1 = 0, m_e2 = 0, m_e3 = 0;
  int     m_code = 8;
  bit     m_clip = 1'b0;
  bit     m_valid = 1'b0;

  always #5ns clk_i = ~clk_i;

  ns3_noise_shaper dut_i (
    .clk_i, .rst_ni, .clr_i, .rate_sel_i, .en_lo_i, .en_hi_i,
    .sample_i, .code_o, .valid_o, .clip_o
  );

  task automatic chk(input string tag, input int act, input int exp_v, input string what);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  task automatic model(input longint x, input bit lo, input bit hi, input bit sel, input bit clr);
    longint v, lvl, d;
    if (clr) begin
      m_e1 = 0; m_e2 = 0; m_e3 = 0;
      m_code = 8; m_clip = 0; m_valid = 0;
    end else if (sel ? hi : lo) begin
      v   = x + 3 * m_e1 - 3 * m_e2 + m_e3;
      lvl = (v >>> 20) + 8;
      if (lvl < 0) begin lvl = 0; m_clip = 1; end
      else if (lvl > 15) begin lvl = 15; m_clip = 1; end
      d = v - (lvl - 8) * S;
      if (d > EMAX) d = EMAX;
      if (d < EMIN) d = EMIN;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = d;
      m_code = int'(lvl);
      m_valid = 1;
    end else begin
      m_valid = 0;
    end
  endtask

  task automatic cyc(input string tag, input longint x, input bit lo, input bit hi,
                     input bit sel, input bit clr);
    @(negedge clk_i);
    sample_i = 24'(x); en_lo_i = lo; en_hi_i = hi; rate_sel_i = sel; clr_i = clr;
    @(posedge clk_i);
    #1ns;
    model(x, lo, hi, sel, clr);
    chk(tag, int'(code_o), m_code, "code_o");
    chk(tag, int'(valid_o), int'(m_valid), "valid_o");
    chk(tag, int'(clip_o), int'(m_clip), "clip_o");
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    longint sum, x;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", int'(code_o), 8, "reset code_o");
    chk("R1", int'(valid_o), 0, "reset valid_o");
    chk("R1", int'(clip_o), 0, "reset clip_o");
    rst_ni = 1'b1;

    // R5: zero input stays mid-scale
    for (int i = 0; i < 16; i++) cyc("R5", 0, 1'b0, 1'b1, 1'b1, 1'b0);

    // R4, R8: constant-input sweep, average check
    for (int k = -12; k <= 12; k++) begin
      x = longint'(k) * (S / 4) + longint'(k) * 37;
      cyc("R1", 0, 1'b0, 1'b0, 1'b1, 1'b1);
      sum = 0;
      for (int i = 0; i < 512; i++) begin
        cyc("R4", x, 1'b0, 1'b1, 1'b1, 1'b0);
        sum += longint'(code_o);
      end
      n_vec++;
      if ((sum - 512 * 8) * S - 512 * x > 512 * S ||
          (sum - 512 * 8) * S - 512 * x < -512 * S) begin
        n_bad++;
        $display("FAIL R8 avg actual_sum=%0d expected_sum=%0d", sum, 512 * 8 + (512 * x) / S);
      end
    end

    // R2: unselected strobe ignored, both directions
    cyc("R1", 0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) cyc("R2", 2 * S, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) cyc("R2", 2 * S + 5, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) cyc("R2", -S, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) cyc("R2", -S, 1'b0, 1'b1, 1'b1, 1'b0);

    // R3: sparse strobes with varying input, holds between
    for (int i = 0; i < 90; i++)
      cyc("R3", longint'((i * 151) % 41 - 20) * (S / 8), 1'b0, (i % 3) == 0, 1'b1, 1'b0);

    // R6, R7: overload in both directions, saturating errors
    cyc("R1", 0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) cyc("R6", EMAX, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) cyc("R7", 0, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc("R1", 0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) cyc("R6", EMIN, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc("R7", 0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R1: clear together with a full-scale strobe
    for (int i = 0; i < 10; i++) cyc("R6", EMAX, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc("R1", EMAX, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) cyc("R1", 0, 1'b0, 1'b1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule